// File: doc/BRIEF.md
# Bus-Matching Read Unpacker with Byte Swap

This block sits between the 36-bit read port of a FIFO memory and an output bus whose width can change at run time. Every word taken from the FIFO is a full 36-bit long word made of four 9-bit bytes. The block can present that long word in three ways: whole, as two 18-bit words, or as four 9-bit bytes. Narrow pieces are placed on the upper lanes or on the lower lanes of the bus, depending on the endian select. Before any narrowing, the bytes of a freshly fetched long word can be reordered in one of four ways. The reordered long word is then held in an auxiliary register, and the block hands out its pieces one read at a time.

The FIFO side is a valid/ready stream. `fifo_valid` means the FIFO is not empty, and the block raises `fifo_ready` to pop one long word in the same cycle. The consumer side works on read strobes. A strobe on `rd_en` is accepted when one of three things holds: it addresses the mailbox, a piece is still pending, or the FIFO has data. Otherwise the read stalls and has no effect; the consumer keeps `rd_en` high or retries later. Each accepted read updates `out_data` and pulses `out_valid` one cycle later. A size select of `11` turns a read into a direct mailbox read that bypasses sizing and swapping, and it leaves the unpacking state untouched.

Top module: `bm_unpack`

## Requirements
- R1: In long mode (size select `00`), one accepted read pops exactly one FIFO long word and drives all 36 bits of `out_data` with it. The FIFO is only ever read in whole 36-bit words.
- R2: `size_sel` and `big_end` are registered on every rising edge. A read uses the values registered on the edge before it, so a selection changed in the same cycle as a read does not affect that read.
- R3: In word mode (`01`) or byte mode (`10`), the first read of a long word shows its first piece and keeps the rest in the block. Each further read at the same selection shows the next piece and pops nothing. Big-endian (`big_end`=1) starts from the most significant piece and drives lanes [35:18] or [35:27]. Little-endian starts from the least significant piece and drives lanes [17:0] or [8:0].
- R4: In word or byte mode, the `out_data` lanes not used by a read keep their previous values.
- R5: `swap_sel` reorders the bytes of a long word, where byte 3 is bits [35:27] and byte 0 is bits [8:0]. `00` leaves the order unchanged. `01` reverses all four bytes. `10` exchanges the two 18-bit halves. `11` exchanges the two bytes inside each half. Bits inside a byte never move.
- R6: The swap mode is taken on the edge that fetches a long word and stays in force for all pieces of that word. When swapping and narrowing are combined, the swap is applied first and the narrowing second.
- R7: A read under a registered size or endian that differs from the one in force for the held long word always fetches a new long word. Any pieces still pending are discarded.
- R8: A read with size select `11` drives all 36 bits of `out_data` from `mbox_data`, with no swap and no pop. Held pieces, size and endian are left as they were, so the next read at the previous selection continues with the next pending piece.
- R9: `fifo_ready` is high only during a non-mailbox read that needs a new long word, and never while `fifo_valid` is low. A read that needs a word while the FIFO is empty is not accepted and changes nothing.
- R10: After reset `out_data` is zero and `out_valid` is low. `out_valid` is high in the cycle after each accepted read and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe from the consumer |
| size_sel | input | 2 | 00 long, 01 word, 10 byte, 11 mailbox |
| big_end | input | 1 | 1 = big-endian pieces on upper lanes |
| swap_sel | input | 2 | Byte-order mode applied on a fetch |
| fifo_valid | input | 1 | FIFO holds at least one long word |
| fifo_data | input | 36 | Long word at the FIFO head |
| fifo_ready | output | 1 | Pop the FIFO head in this cycle |
| mbox_data | input | 36 | Mailbox register contents |
| out_data | output | 36 | Output register |
| out_valid | output | 1 | An accepted read updated `out_data` last edge |

## Verification
A read strobed before edge N shows its result on `out_data` and `out_valid` just after edge N, so the bench samples half a period later, on the following falling edge. `fifo_ready` is combinational and is sampled 1 ns after the strobe is driven, before the edge that consumes it. A change of size or endian needs one extra edge to be registered. The bench therefore waits one full cycle after each selection change before reading, except in the scenario that tests this delay on purpose. Swap changes act on the fetch edge itself, so they are driven together with the read strobe.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_MBOX = 2'b11
  } size_e;

  // bytes carried by one piece for a given size
  function automatic int piece_bytes(size_e s, int nb);
    case (s)
      SZ_WORD: return nb / 2;
      SZ_BYTE: return 1;
      default: return nb;
    endcase
  endfunction

  // index xor mask realising each swap mode
  function automatic int swap_mask(logic [1:0] m, int nb);
    case (m)
      2'b01:   return nb - 1;
      2'b10:   return nb / 2;
      2'b11:   return nb / 2 - 1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/bm_sel_sample.sv
module bm_sel_sample
  import bm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] size_in,
  input  logic       be_in,
  output size_e      size_q,
  output logic       be_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SZ_LONG;
      be_q   <= 1'b0;
    end else begin
      size_q <= size_e'(size_in);
      be_q   <= be_in;
    end
  end
endmodule

// File: rtl/bm_swap.sv
module bm_swap
  import bm_pkg::*;
#(
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4
) (
  input  logic [NBYTES-1:0][BYTE_W-1:0] din,
  input  logic [1:0]                    mode,
  output logic [NBYTES-1:0][BYTE_W-1:0] dout
);
  always_comb begin
    for (int j = 0; j < NBYTES; j++) begin
      dout[j] = din[j ^ swap_mask(mode, NBYTES)];
    end
  end
endmodule

// File: rtl/bm_lane.sv
module bm_lane
  import bm_pkg::*;
#(
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4,
  localparam int IDX_W = $clog2(NBYTES)
) (
  input  logic [NBYTES-1:0][BYTE_W-1:0] word,
  input  logic [NBYTES-1:0][BYTE_W-1:0] prev,
  input  logic [IDX_W-1:0]              idx,
  input  size_e                         size,
  input  logic                          be,
  output logic [NBYTES-1:0][BYTE_W-1:0] nxt
);
  always_comb begin
    nxt = prev;
    for (int l = 0; l < NBYTES; l++) begin
      int k;
      int src;
      k   = piece_bytes(size, NBYTES);
      src = be ? (l - int'(idx) * k) : (l + int'(idx) * k);
      if (((be && l >= NBYTES - k) || (!be && l < k)) && src >= 0 && src < NBYTES)
        nxt[l] = word[src];
    end
  end
endmodule

// File: rtl/bm_unpack.sv
module bm_unpack
  import bm_pkg::*;
#(
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4,
  localparam int DW    = BYTE_W * NBYTES,
  localparam int IDX_W = $clog2(NBYTES),
  localparam int CNT_W = $clog2(NBYTES) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [1:0]    size_sel,
  input  logic          big_end,
  input  logic [1:0]    swap_sel,
  input  logic          fifo_valid,
  input  logic [DW-1:0] fifo_data,
  output logic          fifo_ready,
  input  logic [DW-1:0] mbox_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);
  size_e size_q;
  logic  be_q;

  bm_sel_sample u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .size_in(size_sel),
    .be_in  (big_end),
    .size_q (size_q),
    .be_q   (be_q)
  );

  logic [NBYTES-1:0][BYTE_W-1:0] swapped, hold, src_word, lane_out;
  size_e            cur_size;
  logic             cur_be;
  logic [CNT_W-1:0] left;
  logic [IDX_W-1:0] idx;
  logic             mbox_sel, sel_new, need_fetch, accept;
  logic [IDX_W-1:0] idx_use;

  bm_swap #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_swap (
    .din (fifo_data),
    .mode(swap_sel),
    .dout(swapped)
  );

  assign mbox_sel   = (size_q == SZ_MBOX);
  assign sel_new    = (size_q != cur_size) || (be_q != cur_be);
  assign need_fetch = (left == '0) || sel_new;
  assign fifo_ready = rd_en && !mbox_sel && need_fetch && fifo_valid;
  assign accept     = rd_en && (mbox_sel || !need_fetch || fifo_valid);
  assign src_word   = fifo_ready ? swapped : hold;
  assign idx_use    = fifo_ready ? '0 : idx;

  bm_lane #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_lane (
    .word(src_word),
    .prev(out_data),
    .idx (idx_use),
    .size(size_q),
    .be  (be_q),
    .nxt (lane_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      cur_size  <= SZ_LONG;
      cur_be    <= 1'b0;
      left      <= '0;
      idx       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept && mbox_sel) begin
        out_data <= mbox_data;
      end else if (accept) begin
        out_data <= lane_out;
        if (fifo_ready) begin
          hold     <= swapped;
          cur_size <= size_q;
          cur_be   <= be_q;
          left     <= CNT_W'(NBYTES / piece_bytes(size_q, NBYTES) - 1);
          idx      <= IDX_W'(1);
        end else begin
          left <= left - 1'b1;
          idx  <= idx + 1'b1;
        end
      end
    end
  end

  // R9
  fifo_pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> fifo_valid);

  // R10
  read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fifo_valid) |=> out_valid);

  // R8
  mbox_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && size_q == SZ_MBOX) |=> (out_data == $past(mbox_data)));

  // R4
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && size_q == SZ_BYTE && be_q && (fifo_valid || left != '0))
      |=> (out_data[DW-BYTE_W-1:0] == $past(out_data[DW-BYTE_W-1:0])));

  // R8
  mbox_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q == SZ_MBOX) |-> !fifo_ready);
endmodule

// File: tb/tb_bm_unpack.sv
module tb_bm_unpack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  size_sel = 2'b00;
  logic        big_end = 1'b0;
  logic [1:0]  swap_sel = 2'b00;
  logic        fifo_valid;
  logic [35:0] fifo_data;
  logic        fifo_ready;
  logic [35:0] mbox_data = 36'h0;
  logic [35:0] out_data;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  logic [35:0] fmem [16];
  int head = 0;
  int tail = 0;
  logic popped;

  always #2 clk = ~clk;

  assign fifo_valid = (head != tail);
  assign fifo_data  = fmem[head % 16];

  bm_unpack dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .size_sel(size_sel),
    .big_end(big_end), .swap_sel(swap_sel), .fifo_valid(fifo_valid),
    .fifo_data(fifo_data), .fifo_ready(fifo_ready), .mbox_data(mbox_data),
    .out_data(out_data), .out_valid(out_valid)
  );

  function automatic logic [35:0] mk(logic [8:0] b3, logic [8:0] b2, logic [8:0] b1, logic [8:0] b0);
    return {b3, b2, b1, b0};
  endfunction

  function automatic logic [35:0] swp(logic [35:0] w, logic [1:0] m);
    case (m)
      2'b01:   return {w[8:0], w[17:9], w[26:18], w[35:27]};
      2'b10:   return {w[17:0], w[35:18]};
      2'b11:   return {w[26:18], w[35:27], w[8:0], w[17:9]};
      default: return w;
    endcase
  endfunction

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [35:0] w);
    fmem[tail % 16] = w;
    tail++;
  endtask

  task automatic setsel(logic [1:0] s, logic be);
    size_sel = s;
    big_end  = be;
    @(posedge clk);
    @(negedge clk);
  endtask

  // one read strobe; returns with outputs ready to sample
  task automatic rd();
    rd_en = 1'b1;
    #1 popped = fifo_ready;
    @(posedge clk);
    #1 rd_en = 1'b0;
    if (popped) head++;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 reset out_data", out_data, 36'h0);
    chk("R10 reset out_valid", {35'h0, out_valid}, 36'h0);
    chk("R9 reset fifo_ready", {35'h0, fifo_ready}, 36'h0);
  endtask

  task automatic t_long();
    logic [35:0] w;
    w = mk(9'h1A3, 9'h0B2, 9'h1C1, 9'h0D0);
    setsel(2'b00, 1'b0);
    push(w);
    swap_sel = 2'b00;
    rd();
    chk("R1 long word", out_data, w);
    chk("R10 out_valid after read", {35'h0, out_valid}, 36'h1);
    chk("R1 one pop", 36'(tail - head), 36'h0);
    for (int m = 1; m < 4; m++) begin
      push(w);
      swap_sel = 2'(m);
      rd();
      chk("R5 swap long", out_data, swp(w, 2'(m)));
    end
    swap_sel = 2'b00;
  endtask

  task automatic t_byte_be();
    logic [35:0] w, p;
    w = mk(9'h111, 9'h022, 9'h133, 9'h044);
    setsel(2'b10, 1'b1);
    push(w);
    p = out_data;
    rd();
    chk("R3 byte BE piece0", {27'h0, out_data[35:27]}, {27'h0, w[35:27]});
    chk("R4 byte BE lower lanes held", {9'h0, out_data[26:0]}, {9'h0, p[26:0]});
    rd();
    chk("R3 byte BE piece1", {27'h0, out_data[35:27]}, {27'h0, w[26:18]});
    rd();
    chk("R3 byte BE piece2", {27'h0, out_data[35:27]}, {27'h0, w[17:9]});
    rd();
    chk("R3 byte BE piece3", {27'h0, out_data[35:27]}, {27'h0, w[8:0]});
    chk("R4 lower lanes still held", {9'h0, out_data[26:0]}, {9'h0, p[26:0]});
    chk("R3 single fetch for four bytes", 36'(tail - head), 36'h0);
  endtask

  task automatic t_word_le_frozen();
    logic [35:0] w, s, p;
    w = mk(9'h0AA, 9'h1BB, 9'h0CC, 9'h1DD);
    s = swp(w, 2'b01);
    setsel(2'b01, 1'b0);
    push(w);
    swap_sel = 2'b01;
    p = out_data;
    rd();
    chk("R6 swap then word LE piece0", {18'h0, out_data[17:0]}, {18'h0, s[17:0]});
    chk("R4 word LE upper lanes held", {18'h0, out_data[35:18]}, {18'h0, p[35:18]});
    swap_sel = 2'b00;
    rd();
    chk("R6 swap frozen piece1", {18'h0, out_data[17:0]}, {18'h0, s[35:18]});
  endtask

  task automatic t_size_change();
    logic [35:0] w1, w2;
    w1 = mk(9'h101, 9'h102, 9'h103, 9'h104);
    w2 = mk(9'h0F1, 9'h0F2, 9'h0F3, 9'h0F4);
    setsel(2'b10, 1'b1);
    push(w1);
    push(w2);
    rd();
    chk("R3 first byte", {27'h0, out_data[35:27]}, {27'h0, w1[35:27]});
    setsel(2'b01, 1'b1);
    rd();
    chk("R7 new size fetches next word", {18'h0, out_data[35:18]}, {18'h0, w2[35:18]});
    chk("R7 both words popped", 36'(tail - head), 36'h0);
  endtask

  task automatic t_mailbox();
    logic [35:0] w, mb;
    w  = mk(9'h1E1, 9'h0E2, 9'h1E3, 9'h0E4);
    mb = 36'h9_8765_4321;
    mbox_data = mb;
    setsel(2'b10, 1'b0);
    push(w);
    rd();
    chk("R3 byte LE piece0", {27'h0, out_data[8:0]}, {27'h0, w[8:0]});
    rd();
    chk("R3 byte LE piece1", {27'h0, out_data[8:0]}, {27'h0, w[17:9]});
    setsel(2'b11, 1'b0);
    rd();
    chk("R8 mailbox read", out_data, mb);
    chk("R8 mailbox pops nothing", 36'(tail - head), 36'h0);
    setsel(2'b10, 1'b0);
    rd();
    chk("R8 resume byte LE piece2", out_data, {mb[35:9], w[26:18]});
    rd();
    chk("R8 resume byte LE piece3", {27'h0, out_data[8:0]}, {27'h0, w[35:27]});
  endtask

  task automatic t_empty();
    logic [35:0] p;
    setsel(2'b00, 1'b0);
    p = out_data;
    rd();
    chk("R9 no pop when empty", {35'h0, popped}, 36'h0);
    chk("R9 stalled read no out_valid", {35'h0, out_valid}, 36'h0);
    chk("R9 stalled read keeps output", out_data, p);
  endtask

  task automatic t_sample_delay();
    logic [35:0] w;
    w = mk(9'h1AB, 9'h0CD, 9'h1EF, 9'h012);
    push(w);
    size_sel = 2'b10;
    big_end  = 1'b1;
    rd();
    chk("R2 read uses previously sampled size", out_data, w);
    chk("R1 pop in long mode", 36'(tail - head), 36'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_long();
    t_byte_be();
    t_word_le_frozen();
    t_size_change();
    t_mailbox();
    t_empty();
    t_sample_delay();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule